// File: doc/BRIEF.md
# SPI Master Controller with Buffered Transmit

This block is a serial peripheral interface controller that drives the bus as its master. A processor reaches it through a small register bus carrying a two-bit address, read and write strobes and an eight-bit data path. There are three registers: a control register, a combined status and setup register, and a data register. Writing the data register fills a one-byte transmit buffer. As soon as the shifter is free, and the block is both enabled and set as master, the buffered byte moves into the shifter. The byte then goes out MSB first on MOSI while the reply from the slave is captured from MISO into the same shifter.

The serial clock comes from the bus clock through a divider picked by a two-bit rate code. Clock polarity and clock phase are both selectable. Four flags report progress and errors: transmit buffer empty, receive buffer full, receive overflow and mode fault. Each flag group drives an interrupt request through its own enable bit. When the slave-select input is pulled low while the block is master and the mode-fault check is turned on, the block gives up its master role, turns itself off and reports a fault.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0x28 and the status register (address 1) reads 0x08. Control bits from 7 down to 0: receive-interrupt enable, reserved, master, polarity, phase, open-drain select, enable, transmit-interrupt enable. Status bits from 7 down to 0: receive full, error-interrupt enable, overflow, mode fault, transmit empty, mode-fault check enable, rate[1:0].
- R2: A write to the data register (address 2) clears transmit-empty and fills the transmit buffer. In the next cycle, if the shifter is idle and both enable and master are 1, the byte moves into the shifter and transmit-empty returns to 1. A byte written while the shifter is busy waits in the buffer, and transmit-empty stays 0.
- R3: Rate code 0, 1, 2 or 3 makes each serial-clock half period 1, 4, 16 or 64 bus cycles, which divides the bus clock by 2, 8, 32 or 128. The first edge comes one half period after the load.
- R4: The idle serial clock level equals the polarity bit. Data goes out MSB first. With phase 0, MOSI carries each bit before its leading edge and MISO is sampled on the leading edge. With phase 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R5: On the sixteenth serial-clock edge, receive-full is set, and in the same cycle the received byte is copied to the receive buffer. A data register read returns the receive buffer.
- R6: If a byte completes while receive-full is still 1, the overflow flag is set and the receive buffer keeps its earlier byte.
- R7: A status read followed by a data read clears receive-full and overflow. A data read with no status read before it clears neither flag.
- R8: With the mode-fault check enabled, master set and slave-select low after its two-stage synchronizer, the fault flag is set and the enable and master bits are cleared. A transfer in progress is aborted and the serial clock returns to idle. The fault flag is cleared by a status read followed by a control write.
- R9: While enable or master is 0, no transfer starts, the serial clock stays idle and a written byte stays buffered.
- R10: The receive request equals receive-full AND its enable. The transmit request equals transmit-empty AND its enable. The error request equals (overflow OR mode fault) AND the error enable.
- R11: Control bit 6 always reads 0, and a write to it has no effect. The open-drain select bit is only stored and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives the clear sequences) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register, combinational |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | input | 1 | Slave-select sense input, active low |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The embedded assertions check, on every cycle, the relationships between flag updates and the events that cause them. When a frame completes, receive-full is set on the next cycle. A completion that overruns a full buffer leaves the buffer unchanged. A fault takes away both enable and master. A transfer only begins from an enabled master, and the serial clock sits at its polarity level whenever the shifter is idle. The exact bit timing for each rate and each polarity/phase pair, the MSB-first order of the data, the two-step clear sequences, the waiting of a second buffered byte and the abort in mid-frame can only be shown by the bench's scenarios. There, a reference model compares every output and the register read-back cycle by cycle.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    localparam int FRAME_BITS = 8;
    localparam int EDGE_CNT   = 2 * FRAME_BITS;
    localparam int EDGE_W     = $clog2(EDGE_CNT);
    localparam int DIV_W      = 7;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2,
        REG_NONE = 2'd3
    } reg_addr_e;

    // Control register, bit 7 first
    typedef struct packed {
        logic rx_ie;
        logic rsvd;
        logic master;
        logic cpol;
        logic cpha;
        logic odrain;
        logic en;
        logic tx_ie;
    } ctrl_t;

    // Status / setup register, bit 7 first
    typedef struct packed {
        logic       rxf;
        logic       err_ie;
        logic       ovf;
        logic       modf;
        logic       txe;
        logic       modf_en;
        logic [1:0] rate;
    } stat_t;

    typedef struct packed {
        logic cpol;
        logic cpha;
    } mode_t;

    localparam ctrl_t CTRL_RST = 8'h28;
    localparam stat_t STAT_RST = 8'h08;

    // Half period of the serial clock minus one, in bus cycles: 4**rate - 1
    function automatic logic [DIV_W-1:0] half_m1(input logic [1:0] rate);
        return (DIV_W'(1) << {rate, 1'b0}) - DIV_W'(1);
    endfunction

endpackage

// File: rtl/spi_ss_sync.sv
module spi_ss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) st_q <= 1'b1;
                else     st_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) st_q <= '1;
                else     st_q <= {st_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/spi_rate_div.sv
module spi_rate_div
    import spi_host_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] lim,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + DIV_W'(1);
    end

    AST_TICK_WHILE_RUN: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt_q == '0); // R3
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng
    import spi_host_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] load_byte,
    input  logic                  abort,
    input  logic                  tick,
    input  mode_t                 mode,
    input  logic                  miso,
    output logic                  sck,
    output logic                  mosi,
    output logic                  busy,
    output logic                  done,
    output logic [FRAME_BITS-1:0] rx_byte
);
    logic [FRAME_BITS-1:0] sh_q;
    logic [EDGE_W-1:0]     edge_q;
    logic                  lat_q, mo_q, phase_q, busy_q;
    logic                  lead, last, in_bit;

    assign lead   = ~edge_q[0];
    assign last   = (edge_q == EDGE_W'(EDGE_CNT - 1));
    assign in_bit = mode.cpha ? miso : lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            edge_q  <= '0;
            lat_q   <= 1'b0;
            mo_q    <= 1'b0;
            phase_q <= 1'b0;
            busy_q  <= 1'b0;
        end else if (busy_q && abort) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            edge_q  <= '0;
        end else if (busy_q && tick) begin
            if (lead) begin
                phase_q <= 1'b1;
                lat_q   <= miso;
                mo_q    <= sh_q[FRAME_BITS-1];
            end else begin
                phase_q <= 1'b0;
                sh_q    <= {sh_q[FRAME_BITS-2:0], in_bit};
            end
            if (last) begin
                busy_q <= 1'b0;
                edge_q <= '0;
            end else begin
                edge_q <= edge_q + EDGE_W'(1);
            end
        end else if (!busy_q && load) begin
            sh_q   <= load_byte;
            busy_q <= 1'b1;
            edge_q <= '0;
        end
    end

    assign busy    = busy_q;
    assign done    = busy_q && !abort && tick && last;
    assign rx_byte = {sh_q[FRAME_BITS-2:0], in_bit};
    assign sck     = mode.cpol ^ phase_q;
    assign mosi    = mode.cpha ? mo_q : sh_q[FRAME_BITS-1];

    AST_EDGE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> (edge_q == '0) && !phase_q); // R4
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       spi_sck,
    output logic       spi_mosi,
    input  logic       spi_miso,
    input  logic       spi_ss_n,
    output logic       irq_rx,
    output logic       irq_tx,
    output logic       irq_err
);
    ctrl_t                 ctrl_q;
    logic                  rxf_q, ovf_q, modf_q, txe_q, err_ie_q, modf_en_q, arm_q;
    logic [1:0]            rate_q;
    logic [FRAME_BITS-1:0] tx_buf_q, rx_buf_q, rx_byte;
    logic                  tx_full_q;
    logic                  busy, done, tick, ss_s, start, abort, fault;
    logic                  wr_ctrl, wr_stat, wr_data, rd_stat, rd_data, clr_rx, clr_modf;
    mode_t                 mode;
    stat_t                 stat_view;
    reg_addr_e             sel;

    assign sel      = reg_addr_e'(bus_addr);
    assign wr_ctrl  = bus_wr && (sel == REG_CTRL);
    assign wr_stat  = bus_wr && (sel == REG_STAT);
    assign wr_data  = bus_wr && (sel == REG_DATA);
    assign rd_stat  = bus_rd && (sel == REG_STAT);
    assign rd_data  = bus_rd && (sel == REG_DATA);
    assign clr_rx   = rd_data && arm_q;
    assign clr_modf = wr_ctrl && arm_q;

    assign mode  = '{cpol: ctrl_q.cpol, cpha: ctrl_q.cpha};
    assign start = tx_full_q && ctrl_q.en && ctrl_q.master && !busy;
    assign abort = !(ctrl_q.en && ctrl_q.master);
    assign fault = modf_en_q && ctrl_q.master && !ss_s;

    spi_ss_sync #(.STAGES(SYNC_STAGES)) u_ss_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (spi_ss_n),
        .dout (ss_s)
    );

    spi_rate_div u_rate_div (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .lim  (half_m1(rate_q)),
        .tick (tick)
    );

    spi_shift_eng u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .load_byte (tx_buf_q),
        .abort     (abort),
        .tick      (tick),
        .mode      (mode),
        .miso      (spi_miso),
        .sck       (spi_sck),
        .mosi      (spi_mosi),
        .busy      (busy),
        .done      (done),
        .rx_byte   (rx_byte)
    );

    // Control register and mode-fault takeover
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
        end else begin
            if (wr_ctrl) begin
                ctrl_q      <= ctrl_t'(bus_wdata);
                ctrl_q.rsvd <= 1'b0;
            end
            if (fault) begin
                ctrl_q.en     <= 1'b0;
                ctrl_q.master <= 1'b0;
            end
        end
    end

    // Setup fields, flags and the read-clear arming
    always_ff @(posedge clk) begin
        if (rst) begin
            err_ie_q  <= STAT_RST.err_ie;
            modf_en_q <= STAT_RST.modf_en;
            rate_q    <= STAT_RST.rate;
            rxf_q     <= STAT_RST.rxf;
            ovf_q     <= STAT_RST.ovf;
            modf_q    <= STAT_RST.modf;
            txe_q     <= STAT_RST.txe;
            tx_full_q <= 1'b0;
            arm_q     <= 1'b0;
        end else begin
            if (wr_stat) begin
                err_ie_q  <= bus_wdata[6];
                modf_en_q <= bus_wdata[2];
                rate_q    <= bus_wdata[1:0];
            end

            if (rd_stat)                 arm_q <= 1'b1;
            else if (rd_data || wr_ctrl) arm_q <= 1'b0;

            if (done)        rxf_q <= 1'b1;
            else if (clr_rx) rxf_q <= 1'b0;

            if (done && rxf_q) ovf_q <= 1'b1;
            else if (clr_rx)   ovf_q <= 1'b0;

            if (fault)         modf_q <= 1'b1;
            else if (clr_modf) modf_q <= 1'b0;

            if (wr_data)    txe_q <= 1'b0;
            else if (start) txe_q <= 1'b1;

            if (wr_data)    tx_full_q <= 1'b1;
            else if (start) tx_full_q <= 1'b0;
        end
    end

    // Data buffers hold their contents through reset
    always_ff @(posedge clk) begin
        if (wr_data)         tx_buf_q <= bus_wdata;
        if (done && !rxf_q)  rx_buf_q <= rx_byte;
    end

    always_comb begin
        stat_view = '{rxf: rxf_q, err_ie: err_ie_q, ovf: ovf_q, modf: modf_q,
                      txe: txe_q, modf_en: modf_en_q, rate: rate_q};
        case (sel)
            REG_CTRL: bus_rdata = ctrl_q;
            REG_STAT: bus_rdata = stat_view;
            REG_DATA: bus_rdata = rx_buf_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_rx  = rxf_q && ctrl_q.rx_ie;
    assign irq_tx  = txe_q && ctrl_q.tx_ie;
    assign irq_err = (ovf_q || modf_q) && err_ie_q;

    AST_TXE_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        start && !wr_data |=> txe_q); // R2
    AST_RXF_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> rxf_q); // R5
    AST_OVF_KEEPS_BUF: assert property (@(posedge clk) disable iff (rst)
        done && rxf_q |=> ovf_q && $stable(rx_buf_q)); // R6
    AST_FAULT_DROPS_MASTER: assert property (@(posedge clk) disable iff (rst)
        fault |=> modf_q && !ctrl_q.en && !ctrl_q.master); // R8
    AST_START_ONLY_MASTER: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ctrl_q.en && ctrl_q.master)); // R9
    AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !busy |-> spi_sck == ctrl_q.cpol); // R4
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.rsvd); // R11
endmodule

// File: tb/test_spi_host_ctrl.sv
module test_spi_host_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       spi_sck, spi_mosi, irq_rx, irq_tx, irq_err;
    logic       spi_miso = 1'b0;
    logic       spi_ss_n = 1'b1;

    always #10 clk = ~clk;

    spi_host_ctrl i_spi_host_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_ss_n(spi_ss_n),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_err(irq_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit reported = 0;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit       m_rxie, m_master, m_cpol, m_cpha, m_odr, m_en, m_txie;
    bit       m_rxf, m_errie, m_ovf, m_modf, m_txe, m_modfen, m_arm;
    int       m_rate;
    bit [7:0] m_txbuf, m_rx, m_sh, rbyte;
    bit       m_txfull, m_rxvalid, m_busy, m_lat, m_mo, m_phase;
    int       m_t, m_s1, m_s2, hp, ed;
    bit       o_fault, o_arm, o_rxf, fin;

    always @(posedge clk) begin
        if (rst) begin
            {m_rxie, m_odr, m_en, m_txie, m_cpol} = '0;
            m_master = 1; m_cpha = 1;
            {m_rxf, m_errie, m_ovf, m_modf, m_modfen, m_arm} = '0;
            m_txe = 1; m_rate = 0; m_txfull = 0; m_rxvalid = 0;
            m_busy = 0; m_t = 0; m_sh = 0; m_lat = 0; m_mo = 0; m_phase = 0;
            m_s1 = 1; m_s2 = 1;
        end else begin
            o_fault = m_modfen && m_master && (m_s2 == 0);
            o_arm = m_arm; o_rxf = m_rxf; fin = 0;
            hp = 1 << (2 * m_rate);
            if (m_busy) begin
                if (!(m_en && m_master)) begin
                    m_busy = 0; m_phase = 0;
                end else begin
                    m_t++;
                    if (m_t % hp == 0) begin
                        ed = m_t / hp - 1;
                        if (ed % 2 == 0) begin
                            m_phase = 1; m_lat = spi_miso; m_mo = m_sh[7];
                        end else begin
                            m_phase = 0;
                            m_sh = {m_sh[6:0], m_cpha ? spi_miso : m_lat};
                            if (ed == 15) begin m_busy = 0; fin = 1; rbyte = m_sh; end
                        end
                    end
                end
            end else if (m_txfull && m_en && m_master) begin
                m_sh = m_txbuf; m_busy = 1; m_t = 0; m_txfull = 0; m_txe = 1;
            end
            if (bus_rd && bus_addr == 2'd1) m_arm = 1;
            if (bus_rd && bus_addr == 2'd2) begin
                if (o_arm) begin m_rxf = 0; m_ovf = 0; end
                m_arm = 0;
            end
            if (bus_wr && bus_addr == 2'd0) begin
                {m_rxie, m_master, m_cpol, m_cpha, m_odr, m_en, m_txie} =
                    {bus_wdata[7], bus_wdata[5:0]};
                if (o_arm) m_modf = 0;
                m_arm = 0;
            end
            if (bus_wr && bus_addr == 2'd1) begin
                m_errie = bus_wdata[6]; m_modfen = bus_wdata[2]; m_rate = int'(bus_wdata[1:0]);
            end
            if (bus_wr && bus_addr == 2'd2) begin
                m_txbuf = bus_wdata; m_txfull = 1; m_txe = 0;
            end
            if (fin) begin
                if (o_rxf) m_ovf = 1;
                else begin m_rx = rbyte; m_rxvalid = 1; end
                m_rxf = 1;
            end
            if (o_fault) begin m_modf = 1; m_en = 0; m_master = 0; end
            m_s2 = m_s1; m_s1 = int'(spi_ss_n);
        end
    end

    function automatic logic [7:0] m_reg(input logic [1:0] a);
        case (a)
            2'd0:    return {m_rxie, 1'b0, m_master, m_cpol, m_cpha, m_odr, m_en, m_txie};
            2'd1:    return {m_rxf, m_errie, m_ovf, m_modf, m_txe, m_modfen, 2'(m_rate)};
            2'd2:    return m_rx;
            default: return 8'h00;
        endcase
    endfunction

    // Per-cycle comparison, sampled away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst) begin
                chk("R3 sck", {7'd0, spi_sck}, {7'd0, m_cpol ^ m_phase});
                chk("R4 mosi", {7'd0, spi_mosi}, {7'd0, m_cpha ? m_mo : m_sh[7]});
                chk("R10 irq", {5'd0, irq_rx, irq_tx, irq_err},
                    {5'd0, m_rxf & m_rxie, m_txe & m_txie, (m_ovf | m_modf) & m_errie});
                if (bus_addr == 2'd0)      chk("R11 ctrl read", bus_rdata, m_reg(2'd0));
                else if (bus_addr == 2'd1) chk("R7 status read", bus_rdata, m_reg(2'd1));
                else if (bus_addr == 2'd2 && m_rxvalid) chk("R5 data read", bus_rdata, m_reg(2'd2));
            end
        end
    end

    // Slave reply: pseudo-random bit stream on MISO
    bit [15:0] lf = 16'hACE1;
    initial begin
        forever begin
            @(negedge clk);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            spi_miso = lf[0];
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0; bus_addr = 2'd1;
    endtask

    task automatic rd(input logic [1:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0; bus_addr = 2'd1;
    endtask

    task automatic peek(input logic [1:0] a, input logic [7:0] mask,
                        input logic [7:0] exp, input string tag);
        bus_addr = a;
        #3;
        chk(tag, bus_rdata & mask, exp & mask);
    endtask

    task automatic wait_done();
        int guard = 0;
        @(negedge clk);
        while ((m_busy || m_txfull) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        cyc(2);
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired before the scenario ended");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] first;
        cyc(3);
        rst = 0;

        // R1: reset values
        peek(2'd0, 8'hFF, 8'h28, "R1 control reset");
        peek(2'd1, 8'hFF, 8'h08, "R1 status reset");

        // R11: reserved bit, open-drain bit stored only; R10 tx request
        wr(2'd0, 8'hFF);
        peek(2'd0, 8'hFF, 8'hBF, "R11 reserved reads 0");
        chk("R10 tx request", {7'd0, irq_tx}, 8'h01);
        wr(2'd0, 8'h28);

        // R9: enabled but not master -> nothing starts
        wr(2'd0, 8'h02);
        wr(2'd2, 8'h3C);
        cyc(20);
        peek(2'd1, 8'hFF, 8'h00, "R9 byte held, txe low");
        chk("R9 sck idle", {7'd0, spi_sck}, 8'h00);
        wr(2'd0, 8'h22);
        wait_done();
        rd(2'd1); rd(2'd2);

        // R2..R5: every rate and every polarity/phase pair
        for (int r = 0; r < 4; r++) begin
            for (int md = 0; md < 4; md++) begin
                wr(2'd1, 8'(r));
                wr(2'd0, 8'h22 | 8'(md << 3));
                wr(2'd2, 8'(8'h5B + 37 * (4 * r + md)));
                peek(2'd1, 8'h08, 8'h00, "R2 txe cleared by write");
                cyc(1);
                peek(2'd1, 8'h08, 8'h08, "R2 txe set on load");
                wait_done();
                peek(2'd1, 8'hFF, 8'h88 | 8'(r), "R5 receive full");
                rd(2'd1); rd(2'd2);
                peek(2'd1, 8'hFF, 8'h08 | 8'(r), "R7 flags cleared");
            end
        end
        wr(2'd1, 8'h00);

        // R6 / R7: overflow keeps the first byte; clear sequence
        wr(2'd0, 8'h22);
        wr(2'd2, 8'h11);
        wait_done();
        first = m_rx;
        wr(2'd2, 8'h77);
        wait_done();
        peek(2'd1, 8'hFF, 8'hA8, "R6 overflow set");
        peek(2'd2, 8'hFF, first, "R6 buffer keeps first byte");
        rd(2'd2);
        peek(2'd1, 8'hFF, 8'hA8, "R7 data read alone clears nothing");
        rd(2'd1); rd(2'd2);
        peek(2'd1, 8'hFF, 8'h08, "R7 status then data clears");

        // R2: second byte waits while the first is shifting
        wr(2'd2, 8'h5A);
        cyc(2);
        wr(2'd2, 8'hC3);
        peek(2'd1, 8'h08, 8'h00, "R2 byte waits while busy");
        wait_done();
        rd(2'd1); rd(2'd2);

        // R10: interrupt requests
        wr(2'd0, 8'hA3);
        wr(2'd1, 8'h40);
        chk("R10 tx request", {6'd0, irq_rx, irq_tx}, 8'h01);
        wr(2'd2, 8'h99);
        wait_done();
        chk("R10 rx request", {7'd0, irq_rx}, 8'h01);
        wr(2'd2, 8'h66);
        wait_done();
        chk("R10 error request", {7'd0, irq_err}, 8'h01);
        rd(2'd1); rd(2'd2);
        chk("R10 error request cleared", {7'd0, irq_err}, 8'h00);

        // R8: mode fault aborts a running transfer
        wr(2'd0, 8'h22);
        wr(2'd1, 8'h07);
        wr(2'd2, 8'hF0);
        cyc(50);
        spi_ss_n = 0;
        cyc(4);
        peek(2'd0, 8'hFF, 8'h00, "R8 enable and master cleared");
        peek(2'd1, 8'h10, 8'h10, "R8 fault flag set");
        chk("R8 sck back to idle", {7'd0, spi_sck}, 8'h00);
        spi_ss_n = 1;
        cyc(4);
        rd(2'd1);
        wr(2'd0, 8'h22);
        peek(2'd1, 8'h10, 8'h00, "R8 fault flag cleared");
        cyc(5);

        summary();
        $finish;
    end
endmodule